// File: doc/BRIEF.md
# Serial memory command decoder with block write protection

This block sits behind a byte-level two-wire slave engine. The engine reports bus start and stop events. It also hands over each received byte together with its position in the transaction. The decoder classifies the first byte of each transaction as one of three kinds of access: the temperature register file, the serial memory, or a utility command. It then returns an acknowledge or no-acknowledge decision for every byte. The R/W flag is taken from bit 0 of the first byte, where 1 means read.

The decoder owns two pieces of state. The first is four write-protect flags, one per 128-byte block. These flags model non-volatile storage, so a reset does not clear them; they start cleared. The second is the active bank bit, which selects one of two 256-byte banks and returns to bank 0 on reset.

Utility commands report results only through the choice of acknowledge or no-acknowledge. They never return data bytes. Changing a protection flag needs a high-voltage indication on address pin 0 for the whole transaction. A write-permit output tells the memory datapath whether a given byte address in the active bank may be written. A write-cycle request marks each stop condition that commits non-volatile data.

Top module: `spd_cmd_decoder`

## Requirements
- R1: A first byte whose upper nibble is 0011 (temperature registers) or 1010 (memory), with bits 3:1 equal to the address pins, is acknowledged and sets `o_tgt` to 1 (temperature) or 2 (memory). A first byte whose bits 3:1 differ from the pins is not acknowledged and leaves `o_tgt` at 0. Any acknowledged utility command sets `o_tgt` to 3. `o_tgt` returns to 0 after a stop. On write transactions to the register file or the memory, every later byte is acknowledged.
- R2: While `i_busy` is high, every first byte is answered with no-acknowledge.
- R3: Upper nibble 0110 with bits 3:1 equal to 001, 100, 101 or 000 and R/W = 0 sets protection on block 0, 1, 2 or 3 respectively. If the block is unprotected, the first byte is acknowledged, and so are the dummy second and third bytes. The stop then sets the flag and pulses `o_wc_req` one cycle later. If the block is already protected, the first byte and every later byte are not acknowledged, and no write cycle is requested.
- R4: A set or clear-all command requires `i_hv` high from the start through the stop. If `i_hv` is low at the third byte, that byte is not acknowledged. If `i_hv` is low at the third byte, or drops at any point before the stop, no flag changes and no write cycle is requested.
- R5: Upper nibble 0110 with bits 3:1 = 011 and R/W = 0, under high voltage, acknowledges three bytes. It clears all four flags and requests a write cycle at the stop.
- R6: The set-protection block codes with R/W = 1 query a block. The first byte is acknowledged when that block is unprotected and not acknowledged when it is protected. No state changes.
- R7: Upper nibble 0110 with bits 3:1 = 110 (bank 0) or 111 (bank 1) and R/W = 0 acknowledges the first and second bytes and not the third. The stop after a third byte selects the bank, and no write cycle is requested.
- R8: Upper nibble 0110 with bits 3:1 = 110 and R/W = 1 is acknowledged when bank 0 is active and not acknowledged when bank 1 is active.
- R9: Every other utility encoding (011 read, 111 read) and every other upper nibble is not acknowledged and has no effect.
- R10: `o_wr_ok` is low exactly when the block holding `i_wr_addr` in the active bank is protected. Bank 0 holds blocks 0 (0x00-0x7F) and 1 (0x80-0xFF); bank 1 holds blocks 2 and 3.
- R11: Reset returns the bank to 0 and clears `o_ack_vld`, `o_ack`, `o_tgt` and `o_wc_req`. Protection flags keep their value across reset and are clear before the first change.
- R12: A memory write that carries at least one data byte after the address byte requests a write cycle at its stop. A memory write that carries only its address byte does not. On read transactions, bytes after the first are never acknowledged by the decoder.
- R13: A repeated start abandons any command pending in the transaction it interrupts.
- R14: `o_ack_vld` and `o_ack` follow `i_byte_vld` by one clock; `o_wc_req` and the bank update follow `i_stop` by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_start | input | 1 | Start or repeated-start event pulse |
| i_stop | input | 1 | Stop event pulse |
| i_byte_vld | input | 1 | A received byte is ready for a decision |
| i_byte | input | 8 | Received byte |
| i_pos | input | 2 | Byte position: 0 first, 1 second, 2 third, 3 fourth or later |
| i_pins | input | 3 | Address pin levels, pin 2 down to pin 0 |
| i_hv | input | 1 | High voltage present on address pin 0 |
| i_busy | input | 1 | Internal memory write in progress |
| i_wr_addr | input | 8 | Byte address queried for write permission |
| o_ack_vld | output | 1 | Decision for the previous byte is valid |
| o_ack | output | 1 | 1 = acknowledge, 0 = no-acknowledge |
| o_tgt | output | 2 | 0 none, 1 temperature, 2 memory, 3 utility |
| o_bank | output | 1 | Active bank |
| o_wr_ok | output | 1 | Write to `i_wr_addr` is permitted |
| o_wc_req | output | 1 | One-cycle non-volatile write-cycle request |

## Verification
A behavioural reference model predicts every output on every clock. It is driven with a set of transaction patterns:

- matching and mismatching pin addresses, which separate address compare from target decode;
- set-protection repeated on the same block, which separates the unprotected path from the protected path;
- the same command with high voltage absent, present, and dropped before the stop, which separates third-byte gating from stop-time gating;
- bank switches followed by queries and permit checks, which expose any error in the mapping from bank and address bit to block;
- a reset in the middle of the sequence, which shows that the bank clears while the protection flags survive.

// File: rtl/spd_cmd_pkg.sv
package spd_cmd_pkg;

    localparam int BYTE_W  = 8;
    localparam int PIN_W   = 3;
    localparam int POS_W   = 2;
    localparam int NUM_BLK = 4;
    localparam int BLK_W   = $clog2(NUM_BLK);
    localparam int NIB_W   = BYTE_W / 2;

    localparam logic [NIB_W-1:0] PRE_TEMP = 4'b0011;
    localparam logic [NIB_W-1:0] PRE_MEM  = 4'b1010;
    localparam logic [NIB_W-1:0] PRE_UTIL = 4'b0110;

    localparam logic [PIN_W-1:0] UC_CLEAR = 3'b011;
    localparam logic [PIN_W-1:0] UC_PAGE0 = 3'b110;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_TEMP = 2'd1,
        TGT_MEM  = 2'd2,
        TGT_UTIL = 2'd3
    } tgt_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_TEMP,
        CMD_MEM,
        CMD_SWP,
        CMD_CWP,
        CMD_RPS,
        CMD_SPA,
        CMD_RPA
    } cmd_e;

    typedef struct packed {
        cmd_e             cmd;
        logic             rd;
        logic [BLK_W-1:0] blk;
        logic             page;
        logic             ack;
    } dec_t;

    function automatic logic is_blk_code(input logic [PIN_W-1:0] code);
        case (code)
            3'b001, 3'b100, 3'b101, 3'b000: is_blk_code = 1'b1;
            default:                        is_blk_code = 1'b0;
        endcase
    endfunction

    function automatic logic [BLK_W-1:0] blk_of_code(input logic [PIN_W-1:0] code);
        case (code)
            3'b001:  blk_of_code = 2'd0;
            3'b100:  blk_of_code = 2'd1;
            3'b101:  blk_of_code = 2'd2;
            default: blk_of_code = 2'd3;
        endcase
    endfunction

    function automatic tgt_e tgt_of_cmd(input cmd_e c);
        case (c)
            CMD_NONE: tgt_of_cmd = TGT_NONE;
            CMD_TEMP: tgt_of_cmd = TGT_TEMP;
            CMD_MEM:  tgt_of_cmd = TGT_MEM;
            default:  tgt_of_cmd = TGT_UTIL;
        endcase
    endfunction

endpackage

// File: rtl/spd_addr_decode.sv
module spd_addr_decode
    import spd_cmd_pkg::*;
(
    input  logic [BYTE_W-1:0]  byte_in,
    input  logic [PIN_W-1:0]   pins,
    input  logic [NUM_BLK-1:0] prot,
    input  logic               bank,
    input  logic               busy,
    output dec_t               dec
);

    logic [NIB_W-1:0] pre;
    logic [PIN_W-1:0] code;
    logic             rd;

    assign pre  = byte_in[BYTE_W-1 -: NIB_W];
    assign code = byte_in[PIN_W:1];
    assign rd   = byte_in[0];

    always_comb begin
        dec      = '0;
        dec.cmd  = CMD_NONE;
        dec.rd   = rd;
        dec.blk  = blk_of_code(code);
        dec.page = code[0];
        case (pre)
            PRE_TEMP: begin
                if (code == pins) begin
                    dec.cmd = CMD_TEMP;
                    dec.ack = 1'b1;
                end
            end
            PRE_MEM: begin
                if (code == pins) begin
                    dec.cmd = CMD_MEM;
                    dec.ack = 1'b1;
                end
            end
            PRE_UTIL: begin
                if (is_blk_code(code)) begin
                    dec.cmd = rd ? CMD_RPS : CMD_SWP;
                    dec.ack = !prot[blk_of_code(code)];
                end else if (code == UC_CLEAR && !rd) begin
                    dec.cmd = CMD_CWP;
                    dec.ack = 1'b1;
                end else if (code[PIN_W-1:1] == UC_PAGE0[PIN_W-1:1] && !rd) begin
                    dec.cmd = CMD_SPA;
                    dec.ack = 1'b1;
                end else if (code == UC_PAGE0 && rd) begin
                    dec.cmd = CMD_RPA;
                    dec.ack = !bank;
                end
            end
            default: ;
        endcase
        if (busy) begin
            dec.ack = 1'b0;
        end
    end

endmodule

// File: rtl/spd_prot_store.sv
module spd_prot_store
    import spd_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [BLK_W-1:0]   set_blk,
    input  logic               clr_all,
    input  logic               bank_wr,
    input  logic               bank_val,
    input  logic [BYTE_W-1:0]  chk_addr,
    output logic [NUM_BLK-1:0] prot,
    output logic               bank,
    output logic               wr_ok
);

    logic             bank_q;
    logic [BLK_W-1:0] chk_blk;

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_flag
        logic flag_q = 1'b0;
        always_ff @(posedge clk) begin
            if (clr_all) begin
                flag_q <= 1'b0;
            end else if (set_en && set_blk == BLK_W'(g)) begin
                flag_q <= 1'b1;
            end
        end
        assign prot[g] = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= 1'b0;
        end else if (bank_wr) begin
            bank_q <= bank_val;
        end
    end

    assign bank    = bank_q;
    assign chk_blk = {bank_q, chk_addr[BYTE_W-1]};
    assign wr_ok   = !prot[chk_blk];

    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(set_en || clr_all) |=> $stable(prot)) else $error("flags moved"); // R3
    AST_BANK_RESET: assert property (@(posedge clk)
        rst |=> !bank_q) else $error("bank not cleared"); // R11
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bank_wr |=> $stable(bank_q)) else $error("bank moved"); // R7
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (prot == '0)) else $error("clear failed"); // R5

endmodule

// File: rtl/spd_cmd_decoder.sv
module spd_cmd_decoder
    import spd_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              i_start,
    input  logic              i_stop,
    input  logic              i_byte_vld,
    input  logic [BYTE_W-1:0] i_byte,
    input  logic [POS_W-1:0]  i_pos,
    input  logic [PIN_W-1:0]  i_pins,
    input  logic              i_hv,
    input  logic              i_busy,
    input  logic [BYTE_W-1:0] i_wr_addr,
    output logic              o_ack_vld,
    output logic              o_ack,
    output logic [1:0]        o_tgt,
    output logic              o_bank,
    output logic              o_wr_ok,
    output logic              o_wc_req
);

    localparam logic [POS_W-1:0] POS_ADDR = POS_W'(0);
    localparam logic [POS_W-1:0] POS_SEC  = POS_W'(1);
    localparam logic [POS_W-1:0] POS_THD  = POS_W'(2);

    dec_t               dec;
    logic [NUM_BLK-1:0] prot;

    cmd_e               s_cmd;
    logic               s_rd;
    logic [BLK_W-1:0]   s_blk;
    logic               s_page;
    logic               s_alive;
    logic               s_hv;
    logic               s_pend;
    tgt_e               tgt_q;

    logic               hv_now;
    logic               byte_ack;
    logic               pend_set;
    logic               act;
    logic               set_en;
    logic               clr_all;
    logic               bank_wr;
    logic               stop_wc;

    spd_addr_decode u_dec (
        .byte_in (i_byte),
        .pins    (i_pins),
        .prot    (prot),
        .bank    (o_bank),
        .busy    (i_busy),
        .dec     (dec)
    );

    spd_prot_store u_store (
        .clk      (clk),
        .rst      (rst),
        .set_en   (set_en),
        .set_blk  (s_blk),
        .clr_all  (clr_all),
        .bank_wr  (bank_wr),
        .bank_val (s_page),
        .chk_addr (i_wr_addr),
        .prot     (prot),
        .bank     (o_bank),
        .wr_ok    (o_wr_ok)
    );

    assign hv_now = s_hv & i_hv;

    always_comb begin
        byte_ack = 1'b0;
        pend_set = 1'b0;
        if (i_pos == POS_ADDR) begin
            byte_ack = dec.ack;
        end else if (s_alive && !s_rd) begin
            case (s_cmd)
                CMD_TEMP: byte_ack = 1'b1;
                CMD_MEM: begin
                    byte_ack = 1'b1;
                    pend_set = 1'b1;
                end
                CMD_SWP, CMD_CWP: begin
                    if (i_pos == POS_SEC) begin
                        byte_ack = 1'b1;
                    end else if (i_pos == POS_THD) begin
                        byte_ack = hv_now;
                        pend_set = hv_now;
                    end
                end
                CMD_SPA: begin
                    byte_ack = (i_pos == POS_SEC);
                    pend_set = (i_pos == POS_THD);
                end
                default: ;
            endcase
        end
    end

    assign act     = s_alive && s_pend && i_stop && !i_start;
    assign set_en  = act && s_cmd == CMD_SWP && hv_now;
    assign clr_all = act && s_cmd == CMD_CWP && hv_now;
    assign bank_wr = act && s_cmd == CMD_SPA;
    assign stop_wc = set_en || clr_all || (act && s_cmd == CMD_MEM);

    always_ff @(posedge clk) begin
        if (rst) begin
            s_cmd     <= CMD_NONE;
            s_rd      <= 1'b0;
            s_blk     <= '0;
            s_page    <= 1'b0;
            s_alive   <= 1'b0;
            s_hv      <= 1'b0;
            s_pend    <= 1'b0;
            tgt_q     <= TGT_NONE;
            o_ack_vld <= 1'b0;
            o_ack     <= 1'b0;
            o_wc_req  <= 1'b0;
        end else begin
            o_ack_vld <= i_byte_vld;
            o_ack     <= i_byte_vld && byte_ack;
            o_wc_req  <= stop_wc;
            if (i_start) begin
                s_cmd   <= CMD_NONE;
                s_alive <= 1'b0;
                s_pend  <= 1'b0;
                s_hv    <= i_hv;
                tgt_q   <= TGT_NONE;
            end else begin
                s_hv <= s_hv & i_hv;
                if (i_stop) begin
                    s_cmd   <= CMD_NONE;
                    s_alive <= 1'b0;
                    s_pend  <= 1'b0;
                    tgt_q   <= TGT_NONE;
                end else if (i_byte_vld) begin
                    if (i_pos == POS_ADDR) begin
                        s_cmd   <= dec.ack ? dec.cmd : CMD_NONE;
                        s_rd    <= dec.rd;
                        s_blk   <= dec.blk;
                        s_page  <= dec.page;
                        s_alive <= dec.ack;
                        s_pend  <= 1'b0;
                        tgt_q   <= dec.ack ? tgt_of_cmd(dec.cmd) : TGT_NONE;
                    end else if (pend_set) begin
                        s_pend <= 1'b1;
                    end
                end
            end
        end
    end

    assign o_tgt = tgt_q;

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (rst)
        (i_byte_vld && i_pos == POS_ADDR && i_busy) |=> (o_ack_vld && !o_ack))
        else $error("busy acked"); // R2
    AST_WC_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        o_wc_req |-> $past(i_stop)) else $error("stray write cycle"); // R14
    AST_PAGE_QUERY: assert property (@(posedge clk) disable iff (rst)
        (i_byte_vld && i_pos == POS_ADDR && i_byte == 8'h6D && !i_busy && !i_stop)
        |=> (o_ack == !o_bank)) else $error("page query"); // R8
    AST_READ_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (i_byte_vld && i_pos != POS_ADDR && s_rd && !i_start) |=> !o_ack)
        else $error("read byte acked"); // R12
    AST_TGT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        i_stop |=> (o_tgt == TGT_NONE)) else $error("target kept"); // R1

endmodule

// File: tb/spd_cmd_decoder_tb.sv
module spd_cmd_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       i_start = 1'b0, i_stop = 1'b0, i_byte_vld = 1'b0;
    logic [7:0] i_byte = 8'h00;
    logic [1:0] i_pos = 2'd0;
    logic [2:0] i_pins = 3'b101;
    logic       i_hv = 1'b0, i_busy = 1'b0;
    logic [7:0] i_wr_addr = 8'h00;
    logic       o_ack_vld, o_ack, o_bank, o_wr_ok, o_wc_req;
    logic [1:0] o_tgt;

    always #5 clk = ~clk;

    spd_cmd_decoder dut_i (
        .clk(clk), .rst(rst), .i_start(i_start), .i_stop(i_stop),
        .i_byte_vld(i_byte_vld), .i_byte(i_byte), .i_pos(i_pos),
        .i_pins(i_pins), .i_hv(i_hv), .i_busy(i_busy), .i_wr_addr(i_wr_addr),
        .o_ack_vld(o_ack_vld), .o_ack(o_ack), .o_tgt(o_tgt), .o_bank(o_bank),
        .o_wr_ok(o_wr_ok), .o_wc_req(o_wc_req)
    );

    int n_chk = 0;
    int n_fail = 0;

    bit m_prot[4] = '{default: 1'b0};
    bit m_bank = 1'b0;
    int e_tgt = 0;
    bit e_vld = 1'b0, e_ack = 1'b0, e_wc = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input string req);
        @(negedge clk);
        chk(req, "ack_vld", int'(o_ack_vld), int'(e_vld));
        chk(req, "ack", int'(o_ack), int'(e_ack));
        chk(req, "tgt", int'(o_tgt), e_tgt);
        chk(req, "bank", int'(o_bank), int'(m_bank));
        chk(req, "wc_req", int'(o_wc_req), int'(e_wc));
        chk(req, "wr_ok", int'(o_wr_ok), int'(!m_prot[{m_bank, i_wr_addr[7]}]));
        e_vld = 1'b0; e_ack = 1'b0; e_wc = 1'b0;
        i_start = 1'b0; i_stop = 1'b0; i_byte_vld = 1'b0;
    endtask

    // kinds: 0 none 1 temp 2 mem 3 set 4 clear 5 query 6 page 7 page query
    task automatic xfer(input string req, input int hv_mode, input int n,
                        input logic [7:0] b0, input logic [7:0] b1 = 8'h00,
                        input logic [7:0] b2 = 8'h00, input logic [7:0] b3 = 8'h00,
                        input bit do_stop = 1'b1);
        logic [7:0] bs[4];
        int  kind = 0;
        int  blk = -1;
        bit  alive = 1'b0, rd = 1'b0, pend = 1'b0, page = 1'b0;
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
        i_hv = (hv_mode != 0);
        i_start = 1'b1;
        e_tgt = 0;
        tick(req);
        for (int k = 0; k < n; k++) begin
            i_byte_vld = 1'b1;
            i_byte = bs[k];
            i_pos = (k > 3) ? 2'd3 : 2'(k);
            e_vld = 1'b1;
            if (k == 0) begin
                rd = bs[0][0];
                case (bs[0][3:1])
                    3'b001: blk = 0;
                    3'b100: blk = 1;
                    3'b101: blk = 2;
                    3'b000: blk = 3;
                    default: blk = -1;
                endcase
                if (bs[0][7:4] == 4'h3 && bs[0][3:1] == i_pins) begin kind = 1; alive = 1'b1; end
                else if (bs[0][7:4] == 4'hA && bs[0][3:1] == i_pins) begin kind = 2; alive = 1'b1; end
                else if (bs[0][7:4] == 4'h6) begin
                    if (blk >= 0) begin kind = rd ? 5 : 3; alive = !m_prot[blk]; end
                    else if (bs[0][3:1] == 3'b011 && !rd) begin kind = 4; alive = 1'b1; end
                    else if (bs[0][3:2] == 2'b11 && !rd) begin kind = 6; alive = 1'b1; page = bs[0][1]; end
                    else if (bs[0][3:1] == 3'b110 && rd) begin kind = 7; alive = !m_bank; end
                end
                if (i_busy) alive = 1'b0;
                e_ack = alive;
                e_tgt = !alive ? 0 : (kind == 1) ? 1 : (kind == 2) ? 2 : 3;
            end else if (alive && !rd) begin
                if (kind == 1) e_ack = 1'b1;
                else if (kind == 2) begin e_ack = 1'b1; pend = 1'b1; end
                else if (kind == 3 || kind == 4) begin
                    if (k == 1) e_ack = 1'b1;
                    else if (k == 2) begin e_ack = (hv_mode != 0); pend = (hv_mode != 0); end
                end else if (kind == 6) begin
                    e_ack = (k == 1);
                    if (k == 2) pend = 1'b1;
                end
            end
            tick(req);
        end
        if (hv_mode == 2) begin
            i_hv = 1'b0;
            tick(req);
        end
        if (do_stop) begin
            i_stop = 1'b1;
            e_tgt = 0;
            if (alive && pend) begin
                if (kind == 3 && hv_mode == 1) begin m_prot[blk] = 1'b1; e_wc = 1'b1; end
                if (kind == 4 && hv_mode == 1) begin m_prot = '{default: 1'b0}; e_wc = 1'b1; end
                if (kind == 6) m_bank = page;
                if (kind == 2) e_wc = 1'b1;
            end
            tick(req);
            i_hv = 1'b0;
            tick(req);
        end
    endtask

    task automatic permit_sweep(input string req);
        logic [7:0] probe[4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        for (int a = 0; a < 4; a++) begin
            i_wr_addr = probe[a];
            tick(req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog run not finished actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        tick("R11");
        rst = 1'b0;
        tick("R11");
        permit_sweep("R11");

        // R1 register file write, then wrong pins
        xfer("R1", 0, 4, 8'h3A, 8'h02, 8'h12, 8'h34);
        xfer("R1", 0, 2, 8'h36, 8'h01);
        xfer("R1", 0, 1, 8'h3B);
        // R12 memory write with data, and a read whose bytes are not acked
        xfer("R12", 0, 3, 8'hAA, 8'h10, 8'h55);
        xfer("R13", 0, 2, 8'hAA, 8'h20, 8'h00, 8'h00, 1'b0);
        xfer("R12", 0, 3, 8'hAB, 8'h00, 8'h00);
        // R2 busy
        i_busy = 1'b1;
        xfer("R2", 0, 1, 8'hAA);
        xfer("R2", 1, 3, 8'h62, 8'h00, 8'h00);
        i_busy = 1'b0;
        // R3 set protection on block 1, then repeat
        i_wr_addr = 8'h80;
        xfer("R3", 1, 3, 8'h68, 8'h00, 8'h00);
        xfer("R3", 1, 3, 8'h68, 8'h00, 8'h00);
        // R6 queries
        xfer("R6", 0, 2, 8'h69, 8'h00);
        xfer("R6", 0, 2, 8'h63, 8'h00);
        // R4 gating: absent, then dropped before stop
        i_wr_addr = 8'h00;
        xfer("R4", 0, 3, 8'h62, 8'h00, 8'h00);
        xfer("R4", 2, 3, 8'h62, 8'h00, 8'h00);
        // R13 restart abandons a pending set
        xfer("R13", 1, 3, 8'h62, 8'h00, 8'h00, 8'h00, 1'b0);
        xfer("R13", 0, 1, 8'h3B);
        // R7 select bank 1, R8 query
        xfer("R7", 0, 3, 8'h6E, 8'h00, 8'h00);
        xfer("R8", 0, 1, 8'h6D);
        xfer("R3", 1, 4, 8'h6A, 8'h00, 8'h00, 8'h00);
        permit_sweep("R10");
        xfer("R7", 0, 3, 8'h6C, 8'h00, 8'h00);
        xfer("R8", 0, 1, 8'h6D);
        permit_sweep("R10");
        // R9 reserved encodings
        xfer("R9", 1, 3, 8'h6F, 8'h00, 8'h00);
        xfer("R9", 1, 3, 8'h67, 8'h00, 8'h00);
        xfer("R9", 1, 3, 8'h4A, 8'h00, 8'h00);
        // R11 reset in bank 1 keeps flags
        xfer("R7", 0, 3, 8'h6E, 8'h00, 8'h00);
        rst = 1'b1;
        m_bank = 1'b0;
        tick("R11");
        rst = 1'b0;
        permit_sweep("R11");
        // R5 clear all
        xfer("R5", 1, 3, 8'h66, 8'h00, 8'h00);
        permit_sweep("R5");
        xfer("R14", 0, 3, 8'hAA, 8'h00, 8'h11);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule